// File: doc/BRIEF.md
# Register-Programmed Single-Channel DMA Mover

This block is one DMA transfer channel that software sets up through a small register file. Software writes a source address, a destination address, a control word for each side and a transfer control word. It then arms the channel through the mask/trigger register. Each unit (byte, halfword or word) moves in two beats on a one-beat master port: a read from the current source address, then a write of the captured data to the current destination address. After each unit, each address side either steps by the unit size or stays fixed. The remaining-unit counter then counts down.

A transfer starts on a request. The request is either the self-clearing software trigger bit or a rising edge on one selected line of eight hardware request inputs. In whole-service mode one request moves the entire count. In single-service mode each request moves one unit, and with hardware triggering a one-cycle acknowledge returns on the selected line after each unit. When the final unit completes, the channel turns itself off and can raise a one-cycle interrupt. A stop command halts it at once and raises no interrupt.

The master port uses valid/ready. `m_valid` rises when the engine has a beat to issue. While `m_ready` is low, the engine holds address, direction, size and write data. A beat completes on a clock edge that sees both signals high, and read data must be valid in that same cycle. The only exception is a stop command, which may withdraw a pending beat.

Top module: `regdma_channel`

## Requirements
- R1: After reset the status register reads 0, the mask/trigger register reads 0, `irq` is low, `hw_ack` is all zero and `m_valid` is low.
- R2: These registers read back what was written:
  - source address at 0x00 and destination address at 0x08;
  - source control at 0x04 and destination control at 0x0C, bits 1:0 only;
  - transfer control at 0x10, all 32 bits.
- R3: The unit size is set by transfer control bits 21:20 (0 byte, 1 halfword, 2 word) and appears on `m_size`. A side whose control bit 0 is clear steps its address by 1, 2 or 4 after every unit.
- R4: A side whose control bit 0 is set uses the same address for every unit of the transfer.
- R5: Each unit is one read beat at the source address followed by one write beat carrying the read data to the destination address. A beat stalled by low `m_ready` keeps `m_valid`, address and direction unchanged until it completes.
- R6: Status bit 20 reads 1 while the channel is on. Status bits 19:0 give the remaining unit count, loaded from transfer control bits 19:0 when the channel is armed and reduced by one per completed unit.
- R7: When the last unit completes, the channel clears its on bit and busy. `irq` pulses for exactly one cycle if transfer control bit 29 is set, and stays low if it is clear.
- R8: Mask/trigger bit 0 (software trigger) reads back as 0 one cycle after it is written.
- R9: With transfer control bit 27 set (whole service), a single request moves every remaining unit.
- R10: With bit 27 clear (single service), each request moves one unit, and the channel then waits, on, for the next request.
- R11: Hardware triggering is selected by transfer control bit 23, and bits 26:24 pick which `hw_req` line is used. In this mode:
  - only a rising edge on the selected line starts service; a level held high gives one request, and other lines are ignored;
  - in single service the matching `hw_ack` bit pulses once after each unit.
- R12: A write to mask/trigger with bit 2 set, or with bit 1 clear, while the channel is on turns it off in that same write. Busy clears, no later beat is issued and no interrupt is raised.
- R13: Writing bit 1 of mask/trigger (turn on) while the transfer count is 0 leaves the channel off and issues no beat.
- R14: `m_bus` equals bit 1 of the source control word during read beats and bit 1 of the destination control word during write beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` (combinational) |
| hw_req | input | 8 | Hardware request lines |
| hw_ack | output | 8 | One-cycle acknowledge on the selected request line |
| irq | output | 1 | Completion interrupt pulse |
| m_valid | output | 1 | Master beat valid |
| m_ready | input | 1 | Master beat accepted |
| m_write | output | 1 | 1 = write beat, 0 = read beat |
| m_addr | output | 32 | Beat address |
| m_size | output | 2 | Unit size code |
| m_bus | output | 1 | Bus location of the current side (1 = peripheral bus) |
| m_wdata | output | 32 | Write beat data |
| m_rdata | input | 32 | Read beat data, valid with `m_ready` |

## Verification
The properties assume the following about the inputs:
- `hw_req` is synchronous to `clk`;
- `m_rdata` is meaningful in the cycle `m_ready` is high;
- software leaves the address, control and transfer registers alone while the channel is on;
- programmed addresses are aligned to the unit size.

The stimulus stays within these limits. It rewrites configuration only after reading status busy as 0. It changes `hw_req` and `m_ready` only between clock edges. It uses aligned addresses only.

The stimulus also exercises back-pressure. A repeating stall pattern on `m_ready` checks that stalled beats hold steady.

// File: rtl/regdma_pkg.sv
package regdma_pkg;
  localparam int REG_AW   = 6;
  localparam int REG_DW   = 32;
  localparam int CNT_W    = 20;
  localparam int NUM_REQ  = 8;
  localparam int SEL_W    = $clog2(NUM_REQ);

  localparam logic [REG_AW-1:0] OFS_SRC  = 6'h00;
  localparam logic [REG_AW-1:0] OFS_SCTL = 6'h04;
  localparam logic [REG_AW-1:0] OFS_DST  = 6'h08;
  localparam logic [REG_AW-1:0] OFS_DCTL = 6'h0C;
  localparam logic [REG_AW-1:0] OFS_XCTL = 6'h10;
  localparam logic [REG_AW-1:0] OFS_STAT = 6'h14;
  localparam logic [REG_AW-1:0] OFS_MASK = 6'h20;

  localparam int XC_SIZE_LO = 20;
  localparam int XC_HWTRIG  = 23;
  localparam int XC_SEL_LO  = 24;
  localparam int XC_WHOLE   = 27;
  localparam int XC_IE      = 29;

  localparam int MK_SWTRIG = 0;
  localparam int MK_ON     = 1;
  localparam int MK_STOP   = 2;

  typedef enum logic [1:0] {ENG_IDLE, ENG_RD, ENG_WR} eng_state_t;
endpackage

// File: rtl/regdma_addr_step.sv
module regdma_addr_step #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr_i,
  input  logic          fixed_i,
  input  logic [1:0]    size_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] inc;

  always_comb begin
    case (size_i)
      2'd0:    inc = AW'(1);
      2'd1:    inc = AW'(2);
      default: inc = AW'(4);
    endcase
    addr_o = fixed_i ? addr_i : addr_i + inc;
  end
endmodule

// File: rtl/regdma_req_sel.sv
module regdma_req_sel #(
  parameter int NREQ = 8,
  parameter int SW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] hw_req,
  input  logic [SW-1:0]   sel,
  input  logic            hw_mode,
  input  logic            single_mode,
  input  logic            sw_trig,
  input  logic            unit_done,
  output logic            req_o,
  output logic [NREQ-1:0] hw_ack
);
  logic [NREQ-1:0] req_prev;
  logic [NREQ-1:0] rise;
  logic            ack_fire;

  always_ff @(posedge clk) begin
    if (!rst_n) req_prev <= '0;
    else        req_prev <= hw_req;
  end

  assign rise     = hw_req & ~req_prev;
  assign req_o    = hw_mode ? rise[sel] : sw_trig;
  assign ack_fire = unit_done && hw_mode && single_mode;

  for (genvar i = 0; i < NREQ; i++) begin : g_ack
    assign hw_ack[i] = ack_fire && (sel == SW'(i));
  end
endmodule

// File: rtl/regdma_engine.sv
module regdma_engine
  import regdma_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm_i,
  input  logic          stop_i,
  input  logic          req_i,
  input  logic          whole_i,
  input  logic [1:0]    size_i,
  input  logic          src_fix_i,
  input  logic          dst_fix_i,
  input  logic          src_bus_i,
  input  logic          dst_bus_i,
  input  logic [CW-1:0] load_cnt_i,
  input  logic [AW-1:0] src_base_i,
  input  logic [AW-1:0] dst_base_i,
  output logic          active_o,
  output logic [CW-1:0] cnt_o,
  output logic          unit_done_o,
  output logic          last_done_o,
  output logic          m_valid,
  input  logic          m_ready,
  output logic          m_write,
  output logic [AW-1:0] m_addr,
  output logic [1:0]    m_size,
  output logic          m_bus,
  output logic [DW-1:0] m_wdata,
  input  logic [DW-1:0] m_rdata
);
  eng_state_t    state;
  logic [AW-1:0] src_cur, dst_cur, src_nxt, dst_nxt;
  logic [CW-1:0] cnt;
  logic [DW-1:0] hold;
  logic          active;
  logic          wr_fire, is_last;

  regdma_addr_step #(.AW(AW)) u_src_step (
    .addr_i(src_cur), .fixed_i(src_fix_i), .size_i(size_i), .addr_o(src_nxt));
  regdma_addr_step #(.AW(AW)) u_dst_step (
    .addr_i(dst_cur), .fixed_i(dst_fix_i), .size_i(size_i), .addr_o(dst_nxt));

  assign wr_fire = (state == ENG_WR) && m_ready;
  assign is_last = (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ENG_IDLE;
      active      <= 1'b0;
      cnt         <= '0;
      src_cur     <= '0;
      dst_cur     <= '0;
      hold        <= '0;
      unit_done_o <= 1'b0;
      last_done_o <= 1'b0;
    end else begin
      unit_done_o <= wr_fire && !stop_i;
      last_done_o <= wr_fire && !stop_i && is_last;
      if (stop_i) begin
        active <= 1'b0;
        state  <= ENG_IDLE;
      end else if (arm_i) begin
        active  <= 1'b1;
        cnt     <= load_cnt_i;
        src_cur <= src_base_i;
        dst_cur <= dst_base_i;
        state   <= ENG_IDLE;
      end else begin
        case (state)
          ENG_IDLE: if (active && req_i) state <= ENG_RD;
          ENG_RD: if (m_ready) begin
            hold  <= m_rdata;
            state <= ENG_WR;
          end
          ENG_WR: if (m_ready) begin
            cnt     <= cnt - CW'(1);
            src_cur <= src_nxt;
            dst_cur <= dst_nxt;
            if (is_last) begin
              active <= 1'b0;
              state  <= ENG_IDLE;
            end else if (whole_i) begin
              state <= ENG_RD;
            end else begin
              state <= ENG_IDLE;
            end
          end
          default: state <= ENG_IDLE;
        endcase
      end
    end
  end

  assign active_o = active;
  assign cnt_o    = cnt;
  assign m_valid  = (state != ENG_IDLE);
  assign m_write  = (state == ENG_WR);
  assign m_addr   = m_write ? dst_cur : src_cur;
  assign m_bus    = m_write ? dst_bus_i : src_bus_i;
  assign m_size   = size_i;
  assign m_wdata  = hold;
endmodule

// File: rtl/regdma_channel.sv
module regdma_channel
  import regdma_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [REG_AW-1:0] cfg_addr,
  input  logic [REG_DW-1:0] cfg_wdata,
  output logic [REG_DW-1:0] cfg_rdata,
  input  logic [NUM_REQ-1:0] hw_req,
  output logic [NUM_REQ-1:0] hw_ack,
  output logic              irq,
  output logic              m_valid,
  input  logic              m_ready,
  output logic              m_write,
  output logic [AW-1:0]     m_addr,
  output logic [1:0]        m_size,
  output logic              m_bus,
  output logic [DW-1:0]     m_wdata,
  input  logic [DW-1:0]     m_rdata
);
  logic [AW-1:0]     src_base, dst_base;
  logic [1:0]        src_ctl, dst_ctl;
  logic [REG_DW-1:0] xctl;
  logic              sw_trig;
  logic              chan_on;
  logic [CNT_W-1:0]  cur_cnt;
  logic              unit_done, last_done, req;
  logic              mask_wr, arm, stop_w;

  assign mask_wr = cfg_we && (cfg_addr == OFS_MASK);
  assign arm     = mask_wr && cfg_wdata[MK_ON] && !cfg_wdata[MK_STOP] &&
                   !chan_on && (xctl[CNT_W-1:0] != '0);
  assign stop_w  = mask_wr && chan_on &&
                   (cfg_wdata[MK_STOP] || !cfg_wdata[MK_ON]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_base <= '0;
      dst_base <= '0;
      src_ctl  <= '0;
      dst_ctl  <= '0;
      xctl     <= '0;
      sw_trig  <= 1'b0;
    end else begin
      sw_trig <= mask_wr && cfg_wdata[MK_SWTRIG];
      if (cfg_we) begin
        case (cfg_addr)
          OFS_SRC:  src_base <= AW'(cfg_wdata);
          OFS_SCTL: src_ctl  <= cfg_wdata[1:0];
          OFS_DST:  dst_base <= AW'(cfg_wdata);
          OFS_DCTL: dst_ctl  <= cfg_wdata[1:0];
          OFS_XCTL: xctl     <= cfg_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (cfg_addr)
      OFS_SRC:  cfg_rdata = REG_DW'(src_base);
      OFS_SCTL: cfg_rdata = {30'b0, src_ctl};
      OFS_DST:  cfg_rdata = REG_DW'(dst_base);
      OFS_DCTL: cfg_rdata = {30'b0, dst_ctl};
      OFS_XCTL: cfg_rdata = xctl;
      OFS_STAT: cfg_rdata = {11'b0, chan_on, cur_cnt};
      OFS_MASK: cfg_rdata = {29'b0, 1'b0, chan_on, sw_trig};
      default:  cfg_rdata = '0;
    endcase
  end

  regdma_req_sel #(.NREQ(NUM_REQ), .SW(SEL_W)) u_req (
    .clk(clk), .rst_n(rst_n), .hw_req(hw_req),
    .sel(xctl[XC_SEL_LO +: SEL_W]), .hw_mode(xctl[XC_HWTRIG]),
    .single_mode(!xctl[XC_WHOLE]), .sw_trig(sw_trig),
    .unit_done(unit_done), .req_o(req), .hw_ack(hw_ack));

  regdma_engine #(.AW(AW), .DW(DW), .CW(CNT_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .stop_i(stop_w), .req_i(req),
    .whole_i(xctl[XC_WHOLE]), .size_i(xctl[XC_SIZE_LO +: 2]),
    .src_fix_i(src_ctl[0]), .dst_fix_i(dst_ctl[0]),
    .src_bus_i(src_ctl[1]), .dst_bus_i(dst_ctl[1]),
    .load_cnt_i(xctl[CNT_W-1:0]), .src_base_i(src_base), .dst_base_i(dst_base),
    .active_o(chan_on), .cnt_o(cur_cnt), .unit_done_o(unit_done),
    .last_done_o(last_done), .m_valid(m_valid), .m_ready(m_ready),
    .m_write(m_write), .m_addr(m_addr), .m_size(m_size), .m_bus(m_bus),
    .m_wdata(m_wdata), .m_rdata(m_rdata));

  assign irq = last_done && xctl[XC_IE];
endmodule

// File: rtl/regdma_channel_chk.sv
module regdma_channel_chk
  import regdma_pkg::*;
#(
  parameter int AW = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [REG_AW-1:0] cfg_addr,
  input logic [REG_DW-1:0] cfg_wdata,
  input logic              m_valid,
  input logic              m_ready,
  input logic              m_write,
  input logic [AW-1:0]     m_addr,
  input logic              irq,
  input logic [NUM_REQ-1:0] hw_ack,
  input logic              busy,
  input logic [CNT_W-1:0]  cnt
);
  logic halt_cmd;
  assign halt_cmd = cfg_we && (cfg_addr == OFS_MASK) && busy &&
                    (cfg_wdata[MK_STOP] || !cfg_wdata[MK_ON]);

  assert_beat_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready && !halt_cmd |=> m_valid && $stable(m_addr) && $stable(m_write));

  assert_irq_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  assert_irq_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !busy);

  assert_count_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || cnt <= $past(cnt)));

  assert_ack_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hw_ack));

  assert_stop_halt_R12: assert property (@(posedge clk) disable iff (!rst_n)
    halt_cmd |=> !busy && !m_valid && !irq);

  assert_bus_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !m_valid);
endmodule

bind regdma_channel regdma_channel_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .m_valid(m_valid), .m_ready(m_ready),
  .m_write(m_write), .m_addr(m_addr), .irq(irq), .hw_ack(hw_ack),
  .busy(chan_on), .cnt(cur_cnt));

// File: tb/regdma_channel_test.sv
module regdma_channel_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [7:0]  hw_req = '0;
  logic [7:0]  hw_ack;
  logic        irq;
  logic        m_valid, m_ready = 1'b1, m_write, m_bus;
  logic [31:0] m_addr, m_wdata, m_rdata;
  logic [1:0]  m_size;

  int vectors = 0;
  int fails = 0;
  int irq_cnt = 0;
  int ack_cnt [8];
  bit stall = 1'b0;
  bit done_flag = 1'b0;

  typedef struct {
    logic [31:0] addr;
    logic [31:0] data;
    logic [1:0]  size;
    logic        bus;
  } beat_t;
  beat_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] mdata(logic [31:0] a);
    return {a[15:0] ^ 16'hC3A5, ~a[15:0]};
  endfunction

  assign m_rdata = mdata(m_addr);

  regdma_channel uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .hw_req(hw_req),
    .hw_ack(hw_ack), .irq(irq), .m_valid(m_valid), .m_ready(m_ready),
    .m_write(m_write), .m_addr(m_addr), .m_size(m_size), .m_bus(m_bus),
    .m_wdata(m_wdata), .m_rdata(m_rdata));

  // memory model: back-pressure pattern, changed between edges
  initial begin
    int phase = 0;
    forever begin
      @(posedge clk);
      #2;
      phase = (phase + 1) % 3;
      m_ready = stall ? (phase == 2) : 1'b1;
    end
  end

  // scoreboard monitor for write beats (R3 R4 R5 R14)
  always @(negedge clk) begin
    if (rst_n && m_valid && m_ready && m_write) begin
      vectors++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R5 unexpected write beat: actual addr=%h expected none", m_addr);
      end else begin
        beat_t e;
        e = exp_q.pop_front();
        if (m_addr !== e.addr || m_wdata !== e.data || m_size !== e.size || m_bus !== e.bus) begin
          fails++;
          $display("FAIL R3/R4/R5/R14 write beat: actual a=%h d=%h s=%0d b=%0d expected a=%h d=%h s=%0d b=%0d",
                   m_addr, m_wdata, m_size, m_bus, e.addr, e.data, e.size, e.bus);
        end
      end
    end
  end

  always @(negedge clk) begin
    if (irq) irq_cnt++;
    for (int i = 0; i < 8; i++) if (hw_ack[i]) ack_cnt[i]++;
  end

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: actual running expected finished");
    finish_run();
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic reg_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 2000; i++) begin
      reg_read(6'h14, s);
      if (!s[20]) break;
    end
  endtask

  function automatic logic [31:0] xc(int cnt, int size, bit hw, int sel, bit whole, bit ie);
    return 32'(cnt) | (32'(size) << 20) | (32'h1 << 22) | (32'(hw) << 23) |
           (32'(sel) << 24) | (32'(whole) << 27) | (32'(ie) << 29);
  endfunction

  // driver: program a transfer and queue its expected write beats
  task automatic setup(input logic [31:0] src, input logic [1:0] sctl,
                       input logic [31:0] dst, input logic [1:0] dctl,
                       input logic [31:0] xctl, input int n);
    logic [31:0] s = src, d = dst;
    logic [31:0] step;
    step = (xctl[21:20] == 2'd0) ? 1 : (xctl[21:20] == 2'd1) ? 2 : 4;
    reg_write(6'h00, src);
    reg_write(6'h04, {30'b0, sctl});
    reg_write(6'h08, dst);
    reg_write(6'h0C, {30'b0, dctl});
    reg_write(6'h10, xctl);
    for (int i = 0; i < n; i++) begin
      beat_t b;
      b.addr = d; b.data = mdata(s); b.size = xctl[21:20]; b.bus = dctl[1];
      exp_q.push_back(b);
      if (!sctl[0]) s = s + step;
      if (!dctl[0]) d = d + step;
    end
  endtask

  initial begin
    logic [31:0] r;
    int irq0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    reg_read(6'h14, r); chk(r == 0, "R1", "status after reset", r, 0);
    reg_read(6'h20, r); chk(r == 0, "R1", "mask after reset", r, 0);
    chk(!irq && !m_valid && hw_ack == 0, "R1", "irq/valid/ack after reset",
        {irq, m_valid, hw_ack}, 0);

    // R2 readback
    reg_write(6'h00, 32'h1234_5670); reg_read(6'h00, r);
    chk(r == 32'h1234_5670, "R2", "source address readback", r, 32'h1234_5670);
    reg_write(6'h0C, 32'hFFFF_FFFF); reg_read(6'h0C, r);
    chk(r == 32'h3, "R2", "destination control readback", r, 3);
    reg_write(6'h10, 32'h0BAD_F00D); reg_read(6'h10, r);
    chk(r == 32'h0BAD_F00D, "R2", "transfer control readback", r, 32'h0BAD_F00D);

    // R9 R3 R7: whole service, word, both incrementing, stalls, interrupt
    stall = 1'b1;
    irq0 = irq_cnt;
    setup(32'h0000_1000, 2'b00, 32'h0000_8000, 2'b00, xc(4, 2, 0, 0, 1, 1), 4);
    reg_write(6'h20, 32'h3);
    reg_read(6'h20, r); chk(r[0] == 1'b0, "R8", "software trigger self-clears", r, 32'h2);
    wait_idle();
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R9", "one request moved all units", exp_q.size(), 0);
    chk(irq_cnt == irq0 + 1, "R7", "single interrupt pulse at completion", irq_cnt - irq0, 1);
    reg_read(6'h14, r); chk(r == 0, "R7", "busy and count cleared", r, 0);

    // R4 R14 R3: halfword, destination fixed on peripheral bus, no interrupt
    irq0 = irq_cnt;
    setup(32'h0000_2002, 2'b10, 32'h0000_3000, 2'b11, xc(3, 1, 0, 0, 1, 0), 3);
    reg_write(6'h20, 32'h3);
    wait_idle();
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R4", "fixed destination beats matched", exp_q.size(), 0);
    chk(irq_cnt == irq0, "R7", "no interrupt when disabled", irq_cnt - irq0, 0);

    // R10 R6: single service, byte, software trigger per unit
    stall = 1'b0;
    setup(32'h0000_4001, 2'b00, 32'h0000_5003, 2'b00, xc(3, 0, 0, 0, 0, 1), 3);
    reg_write(6'h20, 32'h3);
    repeat (20) @(negedge clk);
    reg_read(6'h14, r);
    chk(r == ((32'h1 << 20) | 2), "R10", "one unit per request, still busy", r, (32'h1 << 20) | 2);
    reg_write(6'h20, 32'h3);
    repeat (20) @(negedge clk);
    reg_read(6'h14, r);
    chk(r == ((32'h1 << 20) | 1), "R6", "remaining count after second unit", r, (32'h1 << 20) | 1);
    reg_write(6'h20, 32'h3);
    wait_idle();
    chk(exp_q.size() == 0, "R10", "all single units moved", exp_q.size(), 0);

    // R11 hardware trigger, line 5, single service
    irq0 = irq_cnt;
    for (int i = 0; i < 8; i++) ack_cnt[i] = 0;
    setup(32'h0000_6000, 2'b00, 32'h0000_7000, 2'b00, xc(2, 0, 1, 5, 0, 1), 2);
    reg_write(6'h20, 32'h2);
    @(negedge clk); hw_req[2] = 1'b1;
    repeat (3) @(negedge clk); hw_req[2] = 1'b0;
    repeat (10) @(negedge clk);
    reg_read(6'h14, r);
    chk(r[19:0] == 2, "R11", "other request line ignored", r[19:0], 2);
    hw_req[5] = 1'b1;
    repeat (30) @(negedge clk);
    reg_read(6'h14, r);
    chk(r == ((32'h1 << 20) | 1), "R11", "held level gives one unit", r, (32'h1 << 20) | 1);
    chk(ack_cnt[5] == 1, "R11", "acknowledge after first unit", ack_cnt[5], 1);
    hw_req[5] = 1'b0;
    repeat (2) @(negedge clk);
    hw_req[5] = 1'b1;
    wait_idle();
    hw_req[5] = 1'b0;
    repeat (4) @(negedge clk);
    chk(ack_cnt[5] == 2, "R11", "acknowledge per unit", ack_cnt[5], 2);
    chk(ack_cnt[2] == 0 && ack_cnt[0] == 0, "R11", "no ack on other lines", ack_cnt[2], 0);
    chk(irq_cnt == irq0 + 1 && exp_q.size() == 0, "R7", "hw transfer completes", irq_cnt - irq0, 1);

    // R12 stop mid-transfer
    stall = 1'b1;
    irq0 = irq_cnt;
    setup(32'h0001_0000, 2'b00, 32'h0002_0000, 2'b00, xc(50, 2, 0, 0, 1, 1), 50);
    reg_write(6'h20, 32'h3);
    repeat (20) @(negedge clk);
    reg_write(6'h20, 32'h4);
    exp_q.delete();
    reg_read(6'h14, r);
    chk(r[20] == 1'b0, "R12", "busy cleared by stop", r, 0);
    chk(r[19:0] != 0, "R12", "stop came before completion", r[19:0], 1);
    repeat (30) @(negedge clk);
    chk(!m_valid, "R12", "no beat after stop", m_valid, 0);
    chk(irq_cnt == irq0, "R12", "no interrupt on stop", irq_cnt - irq0, 0);

    // R13 arm with zero count
    stall = 1'b0;
    reg_write(6'h10, xc(0, 2, 0, 0, 1, 1));
    reg_write(6'h20, 32'h3);
    reg_read(6'h20, r);
    chk(r == 0, "R13", "channel stays off with zero count", r, 0);
    repeat (10) @(negedge clk);
    reg_read(6'h14, r);
    chk(r[20] == 1'b0, "R13", "status not busy", r, 0);

    finish_run();
  end
endmodule